// File: doc/BRIEF.md
# Change-of-Flow Trace Capture with Repeat Suppression

This block records the target addresses of change-of-flow events (branches, jumps, calls, returns) into a small first-in first-out trace buffer. An external source reports each event as a one-cycle strobe with its address. The block remembers the last address it stored and drops any event whose address equals it. A tight loop that keeps taking the same branch therefore leaves one entry in the trace instead of filling the buffer with copies.

Capture runs only while three controls are high together: arm, enable and loop-capture mode. When all three first become high, the block starts a fresh session. It empties the buffer and resets the remembered address to zero. A debugger reads the trace one entry at a time. Each read pops the oldest entry, and the entry can be read as a whole word or as separate high and low halves. A count output and a full flag report how many entries the buffer holds.

Top module: `cof_trace_dedup`

## Requirements
- R1: After reset the count output is 0 and the full flag is 0.
- R2: In the cycle where arm, enable and loop mode first become high together, the buffer is emptied and the remembered address becomes 0. A strobe or read in that cycle has no effect, so the count output is 0 one cycle later.
- R3: While capture is active, a strobe whose address differs from the remembered address is appended to the buffer and becomes the remembered address. The oldest entry appears on the word output. Its bits [15:8] appear on the high-half output and its bits [7:0] on the low-half output.
- R4: While capture is active, a strobe whose address equals the remembered address writes nothing, and the count does not change.
- R5: Right after a session starts, a strobe at address 0 is suppressed, because the remembered address is 0.
- R6: The count never exceeds 8. The full flag is high exactly when the count is 8. A new address that arrives while the buffer is full and no read happens in that cycle is dropped, and the remembered address keeps its old value.
- R7: A read strobe while the count is above 0 removes the oldest entry and lowers the count by one. A read strobe while the buffer is empty has no effect.
- R8: A read and a capture in the same cycle both take effect, and the count stays the same. This also holds when the buffer is full.
- R9: While any of arm, enable or loop mode is low, strobes are ignored and the stored entries do not change. Reads still pop entries.
- R10: Suppression compares a new address only with the most recently stored address. An address that matches an older entry is stored again (A, B, A yields three entries).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Arm control |
| en_i | input | 1 | Enable control |
| loop_mode_i | input | 1 | Loop-capture mode select |
| cof_vld_i | input | 1 | Change-of-flow event strobe |
| cof_addr_i | input | ADDR_W | Event address |
| rd_i | input | 1 | Pop the oldest entry |
| rd_data_o | output | ADDR_W | Oldest entry, full word |
| rd_hi_o | output | ADDR_W/2 | Oldest entry, high half |
| rd_lo_o | output | ADDR_W/2 | Oldest entry, low half |
| count_o | output | clog2(DEPTH+1) | Number of stored entries |
| full_o | output | 1 | Buffer holds DEPTH entries |

## Verification
The bench builds the block with its defaults: 16-bit addresses and a depth of 8. With a depth of 8, the buffer fills and overflows within a few dozen cycles, and full-with-read cycles happen often in the random phase. The random phase draws addresses from a pool of five values that includes zero, so repeated addresses and the start-of-session zero case come up constantly. Changes on the arm, enable and mode controls are kept rare, so long sessions alternate with frozen periods and restarts.

// File: rtl/cof_trace_pkg.sv
package cof_trace_pkg;
   localparam int DEF_ADDR_W = 16;
   localparam int DEF_DEPTH  = 8;

   typedef enum logic {
      CTL_OFF = 1'b0,
      CTL_ON  = 1'b1
   } ctl_state_t;
endpackage

// File: rtl/cof_session_ctl.sv
module cof_session_ctl
   import cof_trace_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic en_i,
   input  logic loop_mode_i,
   output logic start_o,
   output logic active_o
);
   ctl_state_t st_q;
   logic       go;

   assign go       = arm_i & en_i & loop_mode_i;
   assign start_o  = go & (st_q == CTL_OFF);
   assign active_o = go & (st_q == CTL_ON);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= CTL_OFF;
      else        st_q <= go ? CTL_ON : CTL_OFF;
   end

   // R2: a start is always followed by a running session or an idle state, never a second start
   p_single_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |=> !start_o);
endmodule

// File: rtl/cof_dedup_filter.sv
module cof_dedup_filter #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              active_i,
   input  logic              cof_vld_i,
   input  logic [ADDR_W-1:0] cof_addr_i,
   input  logic              wr_ok_i,
   output logic              wr_req_o,
   output logic [ADDR_W-1:0] wr_data_o
);
   logic [ADDR_W-1:0] last_q;

   assign wr_req_o  = active_i & cof_vld_i & (cof_addr_i != last_q);
   assign wr_data_o = cof_addr_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   last_q <= '0;
      else if (clear_i)             last_q <= '0;
      else if (wr_req_o && wr_ok_i) last_q <= cof_addr_i;
   end

   p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (last_q == '0));

   p_last_track_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req_o && wr_ok_i && !clear_i) |=> (last_q == $past(cof_addr_i)));

   p_drop_keeps_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear_i && !(wr_req_o && wr_ok_i)) |=> $stable(last_q));
endmodule

// File: rtl/cof_trace_fifo.sv
module cof_trace_fifo #(
   parameter int ADDR_W = 16,
   parameter int DEPTH  = 8,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              wr_req_i,
   input  logic [ADDR_W-1:0] wr_data_i,
   input  logic              rd_req_i,
   output logic              wr_ok_o,
   output logic [ADDR_W-1:0] head_o,
   output logic [CNT_W-1:0]  count_o,
   output logic              full_o
);
   logic [ADDR_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wptr_q, rptr_q;
   logic [CNT_W-1:0]  count_q;
   logic              rd_pop, wr_do;

   assign full_o  = (count_q == CNT_W'(DEPTH));
   assign rd_pop  = rd_req_i & (count_q != '0) & ~clear_i;
   assign wr_ok_o = ~clear_i & (~full_o | rd_pop);
   assign wr_do   = wr_req_i & wr_ok_o;
   assign head_o  = mem[rptr_q];
   assign count_o = count_q;

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (wr_do && (wptr_q == PTR_W'(g))) mem[g] <= wr_data_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q  <= '0;
         rptr_q  <= '0;
         count_q <= '0;
      end else if (clear_i) begin
         wptr_q  <= '0;
         rptr_q  <= '0;
         count_q <= '0;
      end else begin
         if (wr_do)  wptr_q <= wptr_q + PTR_W'(1);
         if (rd_pop) rptr_q <= rptr_q + PTR_W'(1);
         count_q <= count_q + CNT_W'(wr_do) - CNT_W'(rd_pop);
      end
   end

   p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CNT_W'(DEPTH));

   p_full_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (full_o && !rd_req_i && !clear_i) |=> full_o);

   p_pop_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_pop && !wr_do) |=> (count_q == $past(count_q) - CNT_W'(1)));

   p_rw_same_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_pop && wr_do) |=> $stable(count_q));
endmodule

// File: rtl/cof_trace_dedup.sv
module cof_trace_dedup
   import cof_trace_pkg::*;
#(
   parameter int ADDR_W = DEF_ADDR_W,
   parameter int DEPTH  = DEF_DEPTH,
   localparam int HALF_W = ADDR_W / 2,
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm_i,
   input  logic              en_i,
   input  logic              loop_mode_i,
   input  logic              cof_vld_i,
   input  logic [ADDR_W-1:0] cof_addr_i,
   input  logic              rd_i,
   output logic [ADDR_W-1:0] rd_data_o,
   output logic [HALF_W-1:0] rd_hi_o,
   output logic [HALF_W-1:0] rd_lo_o,
   output logic [CNT_W-1:0]  count_o,
   output logic              full_o
);
   if (ADDR_W < 2 || (ADDR_W % 2) != 0) begin : g_bad_width
      $error("cof_trace_dedup: ADDR_W must be even and at least 2");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("cof_trace_dedup: DEPTH must be a power of two, at least 2");
   end

   logic              start, active, wr_req, wr_ok;
   logic [ADDR_W-1:0] wr_data, head;

   cof_session_ctl u_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .arm_i       (arm_i),
      .en_i        (en_i),
      .loop_mode_i (loop_mode_i),
      .start_o     (start),
      .active_o    (active)
   );

   cof_dedup_filter #(.ADDR_W(ADDR_W)) u_filt (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_i    (start),
      .active_i   (active),
      .cof_vld_i  (cof_vld_i),
      .cof_addr_i (cof_addr_i),
      .wr_ok_i    (wr_ok),
      .wr_req_o   (wr_req),
      .wr_data_o  (wr_data)
   );

   cof_trace_fifo #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_i   (start),
      .wr_req_i  (wr_req),
      .wr_data_i (wr_data),
      .rd_req_i  (rd_i),
      .wr_ok_o   (wr_ok),
      .head_o    (head),
      .count_o   (count_o),
      .full_o    (full_o)
   );

   assign rd_data_o = head;
   assign rd_hi_o   = head[ADDR_W-1:HALF_W];
   assign rd_lo_o   = head[HALF_W-1:0];

   p_idle_nocap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!(arm_i && en_i && loop_mode_i) && !rd_i) |=> $stable(count_o));

   p_start_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(arm_i && en_i && loop_mode_i) |=> (count_o == '0));
endmodule

// File: tb/sim_cof_trace_dedup.sv
`timescale 1ns/1ps
module sim_cof_trace_dedup;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        arm = 1'b0, en = 1'b0, mode = 1'b0, vld = 1'b0, rd = 1'b0;
   logic [15:0] addr = '0;
   logic [15:0] rd_data;
   logic [7:0]  rd_hi, rd_lo;
   logic [3:0]  count;
   logic        full;

   int tests = 0, fails = 0;
   bit chk_on = 1'b0;

   logic [15:0] q[$];
   logic [15:0] last_m = '0;
   bit          go_q = 1'b0;

   always #4 clk = ~clk;

   cof_trace_dedup u0 (
      .clk(clk), .rst_n(rst_n), .arm_i(arm), .en_i(en), .loop_mode_i(mode),
      .cof_vld_i(vld), .cof_addr_i(addr), .rd_i(rd),
      .rd_data_o(rd_data), .rd_hi_o(rd_hi), .rd_lo_o(rd_lo),
      .count_o(count), .full_o(full)
   );

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // behavioural reference model
   always @(posedge clk) begin
      bit go, rdok, wrok;
      go = arm & en & mode;
      if (!rst_n) begin
         q.delete(); last_m = '0; go_q = 0;
      end else begin
         if (go && !go_q) begin
            q.delete(); last_m = '0;
         end else begin
            rdok = rd && (q.size() > 0);
            wrok = go && go_q && vld && (addr != last_m) && ((q.size() < 8) || rdok);
            if (rdok) void'(q.pop_front());
            if (wrok) begin q.push_back(addr); last_m = addr; end
         end
         go_q = go;
      end
   end

   always @(negedge clk) begin
      if (chk_on) begin
         chk("R6 count", int'(count), q.size());
         chk("R6 full", int'(full), int'(q.size() == 8));
         if (q.size() > 0) begin
            chk("R3 head", int'(rd_data), int'(q[0]));
            chk("R3 hi", int'(rd_hi), int'(q[0][15:8]));
            chk("R3 lo", int'(rd_lo), int'(q[0][7:0]));
         end
      end
   end

   task automatic cyc(input logic a, input logic e, input logic m,
                      input logic v, input logic [15:0] ad, input logic r);
      arm = a; en = e; mode = m; vld = v; addr = ad; rd = r;
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 count", int'(count), 0);
      chk("R1 full", int'(full), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk_on = 1'b1;
      // R2: strobe in the start cycle is discarded
      cyc(1,1,1, 1,16'h12A4, 0);
      chk("R2 start", int'(count), 0);
      // R5: address 0 suppressed right after start
      cyc(1,1,1, 1,16'h0000, 0);
      chk("R5 zero", int'(count), 0);
      cyc(1,1,1, 1,16'h12A4, 0);
      chk("R3 capture", int'(count), 1);
      chk("R3 hi", int'(rd_hi), 8'h12);
      chk("R3 lo", int'(rd_lo), 8'hA4);
      cyc(1,1,1, 1,16'h12A4, 0);
      chk("R4 repeat", int'(count), 1);
      cyc(1,1,1, 1,16'h5C3E, 0);
      cyc(1,1,1, 1,16'h12A4, 0);
      chk("R10 older match", int'(count), 3);
      cyc(1,1,1, 0,16'h0000, 1);
      chk("R7 pop", int'(rd_data), 16'h5C3E);
      for (int i = 0; i < 7; i++) cyc(1,1,1, 1,16'h0100 + 16'(i), 0);
      chk("R6 full", int'(full), 1);
      cyc(1,1,1, 1,16'h0F0F, 0);
      chk("R6 dropped", int'(count), 8);
      cyc(1,1,1, 1,16'h0F0F, 1);
      chk("R8 read+write", int'(count), 8);
      cyc(0,1,1, 1,16'h7777, 0);
      chk("R9 frozen", int'(count), 8);
      cyc(1,1,0, 1,16'h7778, 1);
      chk("R9 read while off", int'(count), 7);
      for (int i = 0; i < 8; i++) cyc(0,0,0, 0,16'h0, 1);
      chk("R7 empty read", int'(count), 0);
      cyc(1,1,1, 1,16'h3333, 0);
      chk("R2 restart", int'(count), 0);
      for (int i = 0; i < 3000; i++) begin
         int r;
         logic [15:0] pool [5] = '{16'h0000, 16'h0001, 16'h00FF, 16'h1234, 16'hABCD};
         r = $urandom % 100;
         cyc(r > 2, r != 1, r != 0, 1'($urandom % 2), pool[$urandom % 5],
             ($urandom % 4) == 0);
      end
      chk_on = 1'b0;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule